// File: doc/BRIEF.md
# Dual-Rail Selector Handshake Monitor

This block is a passive, synthesizable observer placed beside a selector that has a three-wire one-hot control channel and two dual-rail output channels. Every channel uses a four-phase handshake, and every acknowledge is active-low. The monitor samples the ports on each clock edge and judges both sides of the link. It catches mistakes made by the environment: a control word that changes before it is accepted, a control word that does not return to zero, and acknowledges that arrive late or are released late. It also catches mistakes made by the selector itself: a control request whose writes go to the wrong output, and a control request whose writes never appear.

Each "must eventually" rule is turned into a bounded wait. The rule has a condition. The monitor counts the consecutive clock samples on which that condition holds. It reports a violation once the condition outlasts the parameter `MAX_WAIT`. Every violation sets its own sticky bit, and one summary output is the OR of all the bits. The monitor drives nothing and does not look at the data values that are carried.

Top module: `dr_select_monitor`

## Requirements
- R1: While reset is low, and until the first violation after reset, `err_flags` is all zero and `err_any` is 0.
- R2: A control value that is nonzero and not one of 3'b001, 3'b010 or 3'b100 sets bit 1 of `err_flags` at the next clock edge.
- R3: A control value that is nonzero and sampled with `ctl_ack` = 1 must be unchanged on the next sample. If it changes, bit 0 is set. A change that follows a sample with `ctl_ack` = 0 is legal.
- R4: The return-to-zero condition is: `ctl` is nonzero, and `ctl_ack` is 0 now or has been 0 since `ctl` was last zero. If this condition holds on more than `MAX_WAIT` consecutive samples, bit 2 is set.
- R5: On output S1 (bit 3) and on output S2 (bit 4), the acknowledge-wait condition is: the acknowledge is 1, and the channel is non-empty now or has been non-empty since the acknowledge was last 0. If it holds on more than `MAX_WAIT` consecutive samples, the bit for that channel is set.
- R6: On S1 (bit 5) and on S2 (bit 6), the release condition is: the acknowledge is 0 while the channel reads 2'b00. If it holds on more than `MAX_WAIT` consecutive samples, the bit for that channel is set.
- R7: A dual-rail value of 2'b11 on either output sets bit 7 at the next clock edge. The values 2'b01 and 2'b10 are data, and 2'b00 is empty.
- R8: A write is a sample where an output changes from 2'b00 to a non-empty value. A request is opened by the first one-hot control value seen while no request is open. Code 3'b001 allows a write on S1 only, 3'b010 on S2 only, and 3'b100 on both. Any write on an output that the open request does not allow sets bit 8.
- R9: Each output that the open request allows must receive a write. The condition "an allowed output still lacks its write" is counted from the sample after the request opens. If it holds on more than `MAX_WAIT` consecutive samples, bit 9 is set. The request closes once all its writes have happened and `ctl` reads 3'b000.
- R10: Every bit of `err_flags` stays set until reset. `err_any` is 1 exactly when any bit of `err_flags` is set.
- R11: A condition that holds on exactly `MAX_WAIT` consecutive samples raises nothing. A break in the run restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases after two clock edges |
| ctl | input | 3 | One-hot control channel value |
| ctl_ack | input | 1 | Control acknowledge, active-low |
| s1_data | input | 2 | Dual-rail output channel S1 |
| s1_ack | input | 1 | S1 acknowledge, active-low |
| s2_data | input | 2 | Dual-rail output channel S2 |
| s2_ack | input | 1 | S2 acknowledge, active-low |
| err_flags | output | 10 | Sticky violation bits, numbered as in the requirements |
| err_any | output | 1 | OR of all violation bits |

## Verification
The bound properties assume that all inputs are synchronous to `clk` and hold their values across each rising edge. They also assume that the control channel sits at zero during reset, so the stability rule has no earlier word to compare against. The stability property starts only after one complete sample following the internal reset release. The bench changes every input just after a falling edge and holds the control and output channels idle during reset. Each scenario starts from a fresh reset, so every sticky bit it observes is caused by that scenario alone.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;

  localparam int NUM_FLAGS       = 10;
  localparam int F_CTL_UNSTABLE  = 0;
  localparam int F_CTL_BADCODE   = 1;
  localparam int F_CTL_RTZ_LATE  = 2;
  localparam int F_S1_ACK_LATE   = 3;
  localparam int F_S2_ACK_LATE   = 4;
  localparam int F_S1_REL_LATE   = 5;
  localparam int F_S2_REL_LATE   = 6;
  localparam int F_OUT_BADCODE   = 7;
  localparam int F_MISROUTE      = 8;
  localparam int F_DELIVER_LATE  = 9;

  localparam int CTL_W  = 3;
  localparam int DR_W   = 2;
  localparam int NUM_CH = 2;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  // Width for a counter that must reach the value lim.
  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
  parameter int MAX_WAIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic expired
);
  import hsmon_pkg::*;

  localparam int             CW    = cnt_width(MAX_WAIT);
  localparam logic [CW-1:0]  LIMIT = CW'(MAX_WAIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);
  assign expired  = cond && at_limit;

  always_comb begin
    if (!cond) begin
      cnt_d = '0;
    end else if (!at_limit) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/hs_out_channel.sv
module hs_out_channel #(
  parameter int MAX_WAIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] data,
  input  logic       ack,
  output logic       wr_evt,
  output logic       bad_code,
  output logic       ack_late,
  output logic       rel_late
);

  logic [1:0] data_q;
  logic       armed_q;
  logic       armed_d;
  logic       nonempty;
  logic       ack_cond;
  logic       rel_cond;

  assign nonempty = (data != 2'b00);
  assign wr_evt   = nonempty && (data_q == 2'b00);
  assign bad_code = (data == 2'b11);

  // Waiting for the active-low acknowledge after data appeared.
  assign ack_cond = ack && (nonempty || armed_q);
  assign armed_d  = ack_cond;

  // Acknowledge still held low after the channel emptied.
  assign rel_cond = !ack && !nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 2'b00;
      armed_q <= 1'b0;
    end else begin
      data_q  <= data;
      armed_q <= armed_d;
    end
  end

  hs_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_ack_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (ack_cond),
    .expired (ack_late)
  );

  hs_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_rel_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (rel_cond),
    .expired (rel_late)
  );

endmodule

// File: rtl/hs_route_tracker.sv
module hs_route_tracker #(
  parameter int MAX_WAIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ctl,
  input  logic [1:0] wr,
  output logic       misroute,
  output logic       deliver_late
);

  logic       open_q;
  logic       open_d;
  logic [1:0] need_q;
  logic [1:0] need_d;
  logic [1:0] allow_q;
  logic [1:0] allow_d;
  logic       req_valid;
  logic       capture;
  logic       open_eff;
  logic [1:0] code_allow;
  logic [1:0] allow_eff;
  logic [1:0] need_eff;
  logic [1:0] need_left;
  logic       deliver_cond;

  assign req_valid  = (ctl == 3'b001) || (ctl == 3'b010) || (ctl == 3'b100);
  assign capture    = !open_q && req_valid;
  assign open_eff   = open_q || capture;
  // bit 0 is S1, bit 1 is S2
  assign code_allow = {ctl[1] | ctl[2], ctl[0] | ctl[2]};
  assign allow_eff  = open_q ? allow_q : code_allow;
  assign need_eff   = open_q ? need_q  : code_allow;
  assign need_left  = need_eff & ~wr;

  assign misroute     = open_eff && ((wr & ~allow_eff) != 2'b00);
  assign deliver_cond = open_q && ((need_q & ~wr) != 2'b00);

  always_comb begin
    open_d  = 1'b0;
    need_d  = 2'b00;
    allow_d = 2'b00;
    if (open_eff) begin
      if ((need_left == 2'b00) && (ctl == 3'b000)) begin
        open_d = 1'b0;
      end else begin
        open_d  = 1'b1;
        need_d  = need_left;
        allow_d = allow_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      need_q  <= 2'b00;
      allow_q <= 2'b00;
    end else begin
      open_q  <= open_d;
      need_q  <= need_d;
      allow_q <= allow_d;
    end
  end

  hs_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_dlv_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (deliver_cond),
    .expired (deliver_late)
  );

endmodule

// File: rtl/dr_select_monitor.sv
module dr_select_monitor #(
  parameter int MAX_WAIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ctl,
  input  logic       ctl_ack,
  input  logic [1:0] s1_data,
  input  logic       s1_ack,
  input  logic [1:0] s2_data,
  input  logic       s2_ack,
  output logic [9:0] err_flags,
  output logic       err_any
);
  import hsmon_pkg::*;

  // Reset: asserts at once, releases on the second clock edge.
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // Control channel checks
  logic [2:0] ctl_q;
  logic       ctl_ack_q;
  logic       rtz_armed_q;
  logic       rtz_cond;
  logic       rtz_late;
  logic       ctl_unstable;
  logic       ctl_badcode;

  assign ctl_unstable = (ctl_q != 3'b000) && ctl_ack_q && (ctl != ctl_q);
  assign ctl_badcode  = (ctl != 3'b000) && ((ctl & (ctl - 3'b001)) != 3'b000);
  assign rtz_cond     = (ctl != 3'b000) && (!ctl_ack || rtz_armed_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q       <= 3'b000;
      ctl_ack_q   <= 1'b1;
      rtz_armed_q <= 1'b0;
    end else begin
      ctl_q       <= ctl;
      ctl_ack_q   <= ctl_ack;
      rtz_armed_q <= rtz_cond;
    end
  end

  hs_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_rtz_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cond    (rtz_cond),
    .expired (rtz_late)
  );

  // Output channels
  logic [DR_W-1:0]   ch_data [NUM_CH];
  logic [NUM_CH-1:0] ch_ack;
  logic [NUM_CH-1:0] ch_wr;
  logic [NUM_CH-1:0] ch_bad;
  logic [NUM_CH-1:0] ch_ack_late;
  logic [NUM_CH-1:0] ch_rel_late;

  assign ch_data[0] = s1_data;
  assign ch_data[1] = s2_data;
  assign ch_ack     = {s2_ack, s1_ack};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    hs_out_channel #(.MAX_WAIT(MAX_WAIT)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .data     (ch_data[g]),
      .ack      (ch_ack[g]),
      .wr_evt   (ch_wr[g]),
      .bad_code (ch_bad[g]),
      .ack_late (ch_ack_late[g]),
      .rel_late (ch_rel_late[g])
    );
  end

  // Routing of requests to writes
  logic misroute;
  logic deliver_late;

  hs_route_tracker #(.MAX_WAIT(MAX_WAIT)) u_route (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ctl          (ctl),
    .wr           (ch_wr),
    .misroute     (misroute),
    .deliver_late (deliver_late)
  );

  // Sticky flags
  flag_vec_t hit;
  flag_vec_t flags_q;
  flag_vec_t flags_d;

  always_comb begin
    hit                 = '0;
    hit[F_CTL_UNSTABLE] = ctl_unstable;
    hit[F_CTL_BADCODE]  = ctl_badcode;
    hit[F_CTL_RTZ_LATE] = rtz_late;
    hit[F_S1_ACK_LATE]  = ch_ack_late[0];
    hit[F_S2_ACK_LATE]  = ch_ack_late[1];
    hit[F_S1_REL_LATE]  = ch_rel_late[0];
    hit[F_S2_REL_LATE]  = ch_rel_late[1];
    hit[F_OUT_BADCODE]  = |ch_bad;
    hit[F_MISROUTE]     = misroute;
    hit[F_DELIVER_LATE] = deliver_late;
    flags_d             = flags_q | hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign err_flags = flags_q;
  assign err_any   = |flags_q;

endmodule

// File: rtl/dr_select_monitor_chk.sv
module dr_select_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ctl,
  input logic       ctl_ack,
  input logic [1:0] s1_data,
  input logic [1:0] s2_data,
  input logic [9:0] err_flags,
  input logic       err_any
);
  import hsmon_pkg::*;

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((err_flags & $past(err_flags)) == $past(err_flags))); // R10

  AST_ANY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> !$fell(err_any)); // R10

  AST_CTL_BADCODE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl != 3'b000) && ($countones(ctl) != 1)) |=> err_flags[F_CTL_BADCODE]); // R2

  AST_DR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((s1_data == 2'b11) || (s2_data == 2'b11)) |=> err_flags[F_OUT_BADCODE]); // R7

  AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(ctl) != 3'b000) && $past(ctl_ack) && (ctl != $past(ctl)))
      |=> err_flags[F_CTL_UNSTABLE]); // R3

endmodule

bind dr_select_monitor dr_select_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctl       (ctl),
  .ctl_ack   (ctl_ack),
  .s1_data   (s1_data),
  .s2_data   (s2_data),
  .err_flags (err_flags),
  .err_any   (err_any)
);

// File: tb/dr_select_monitor_tb.sv
module dr_select_monitor_tb;

  localparam int MW = 4;

  logic       clk;
  logic       rst_n;
  logic [2:0] ctl;
  logic       ctl_ack;
  logic [1:0] s1_data;
  logic       s1_ack;
  logic [1:0] s2_data;
  logic       s2_ack;
  logic [9:0] err_flags;
  logic       err_any;

  int checks;
  int errors;
  bit done;

  dr_select_monitor #(.MAX_WAIT(MW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .ctl_ack   (ctl_ack),
    .s1_data   (s1_data),
    .s1_ack    (s1_ack),
    .s2_data   (s2_data),
    .s2_ack    (s2_ack),
    .err_flags (err_flags),
    .err_any   (err_any)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic idle_inputs();
    ctl     = 3'b000;
    ctl_ack = 1'b1;
    s1_data = 2'b00;
    s1_ack  = 1'b1;
    s2_data = 2'b00;
    s2_ack  = 1'b1;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(input logic [9:0] exp, input string tag);
    checks++;
    if (err_flags !== exp || err_any !== (exp != 10'd0)) begin
      errors++;
      $display("FAIL %s: flags=%b any=%b expected flags=%b any=%b",
               tag, err_flags, err_any, exp, (exp != 10'd0));
    end
  endtask

  // One full transaction described by its delays; expected flags computed
  // from the requirements.
  task automatic run_txn(input logic [2:0] code, input logic [1:0] wmask,
                         input int d, input int k, input int rel, input int rtz,
                         input string tag);
    int a;
    int last;
    logic [1:0] allow;
    logic [9:0] exp;
    do_reset();
    a    = d + k + 1 + rel + 1;
    last = a + rtz + 2 + MW + 4;
    for (int s = 0; s < last; s++) begin
      ctl     = (s < a + rtz) ? code : 3'b000;
      ctl_ack = (s >= a && s < a + rtz + 1) ? 1'b0 : 1'b1;
      s1_data = (wmask[0] && s >= d && s < d + k + 1) ? 2'b01 : 2'b00;
      s2_data = (wmask[1] && s >= d && s < d + k + 1) ? 2'b10 : 2'b00;
      s1_ack  = (wmask[0] && s >= d + k && s < d + k + 1 + rel) ? 1'b0 : 1'b1;
      s2_ack  = (wmask[1] && s >= d + k && s < d + k + 1 + rel) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    allow  = {code[1] | code[2], code[0] | code[2]};
    exp    = '0;
    exp[2] = (rtz > MW);                               // R4
    exp[3] = wmask[0] && (k > MW);                     // R5
    exp[4] = wmask[1] && (k > MW);                     // R5
    exp[5] = wmask[0] && (rel > MW);                   // R6
    exp[6] = wmask[1] && (rel > MW);                   // R6
    exp[8] = ((wmask & ~allow) != 2'b00);              // R8
    exp[9] = ((d - 1) > MW) || ((allow & ~wmask) != 2'b00); // R9
    chk(exp, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [3];
    checks = 0;
    errors = 0;
    done   = 1'b0;
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    chk(10'd0, "R1 during reset");
    do_reset();
    chk(10'd0, "R1 after reset");

    // R2: every control value
    for (int c = 0; c < 8; c++) begin
      logic [2:0] cv;
      logic [9:0] e;
      do_reset();
      cv  = 3'(c);
      ctl = cv;
      @(negedge clk);
      e    = '0;
      e[1] = (cv != 3'b000) && !(cv == 3'b001 || cv == 3'b010 || cv == 3'b100);
      chk(e, "R2 encoding sweep");
    end

    // R7: every dual-rail value on each output
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 4; v++) begin
        logic [9:0] e;
        do_reset();
        if (ch == 0) s1_data = 2'(v);
        else         s2_data = 2'(v);
        @(negedge clk);
        e    = '0;
        e[7] = (v == 3);
        chk(e, "R7 dual-rail sweep");
      end
    end

    // R3: change before acknowledge
    do_reset();
    ctl = 3'b001;
    @(negedge clk);
    ctl = 3'b100;
    @(negedge clk);
    @(negedge clk);
    chk(10'b00_0000_0001, "R3 change while unacknowledged");

    // R3: holding the word across the acknowledge is legal
    do_reset();
    ctl = 3'b010;
    @(negedge clk);
    @(negedge clk);
    chk(10'd0, "R3 held word");

    // Clean transactions for every code (R8, R9, R11 negative)
    codes[0] = 3'b001;
    codes[1] = 3'b010;
    codes[2] = 3'b100;
    for (int i = 0; i < 3; i++) begin
      logic [1:0] al;
      al = {codes[i][1] | codes[i][2], codes[i][0] | codes[i][2]};
      run_txn(codes[i], al, 1, 1, 1, 1, "R8 R9 clean routing");
    end

    // R9 and R11: write delay sweep on the dual request
    for (int d = 1; d <= MW + 3; d++)
      run_txn(3'b100, 2'b11, d, 1, 1, 1, "R9 R11 write delay");

    // R5 and R11: acknowledge delay on each output
    for (int k = 1; k <= MW + 2; k++) begin
      run_txn(3'b001, 2'b01, 1, k, 1, 1, "R5 R11 S1 ack delay");
      run_txn(3'b010, 2'b10, 1, k, 1, 1, "R5 R11 S2 ack delay");
    end

    // R6: release delay on both outputs
    for (int r = 1; r <= MW + 2; r++)
      run_txn(3'b100, 2'b11, 1, 1, r, 1, "R6 R11 release delay");

    // R4: return-to-zero delay
    for (int r = 1; r <= MW + 2; r++)
      run_txn(3'b001, 2'b01, 1, 1, 1, r, "R4 R11 return-to-zero");

    // R8 and R9: wrong or missing routes; R10 flags survive the handshake
    run_txn(3'b001, 2'b10, 1, 1, 1, 1, "R8 R9 R10 S1 request to S2");
    run_txn(3'b010, 2'b01, 1, 1, 1, 1, "R8 R9 R10 S2 request to S1");
    run_txn(3'b001, 2'b11, 1, 1, 1, 1, "R8 R10 extra write on S2");
    run_txn(3'b100, 2'b01, 1, 1, 1, 1, "R9 R10 dual request missing S2");
    run_txn(3'b100, 2'b11, 1, MW + 1, MW + 1, MW + 1, "R4 R5 R6 R10 combined");

    // R1: reset clears sticky flags
    do_reset();
    chk(10'd0, "R1 R10 cleared by reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule